// File: doc/BRIEF.md
# Display SPI Write Serializer

This block turns a stream of bytes into writes on a four-line serial link to a display controller. Each byte arrives on a valid/ready port with a tag that marks it as a command or as pixel data. The block drives chip select low and sets the data/command line from the tag. It then shifts the eight bits out most significant first on a serial clock that it derives from the system clock by counting. After the last bit it holds chip select low for a guard interval before it releases the link.

The serial clock idles low. The receiver samples on its rising edge. Serial data and the data/command line change only while the serial clock is low, which gives a full half period of setup and hold around every sampling edge. Each half period is `HALF_DIV` system clocks, so the default of 10 gives a 200 ns period at 100 MHz. The input port applies back-pressure: `in_ready` drops on the cycle after a byte is accepted. It returns only in the last cycle of the hold interval. If a new byte is valid in that cycle it is taken at once and chip select stays low. Otherwise chip select rises and the block goes idle, with `in_ready` held high.

Top module: `spi_disp_writer`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Each accepted byte produces exactly eight rising edges of `sclk`, and `sdo` carries bit 7 at the first edge down to bit 0 at the eighth.
- R3: At every rising `sclk` edge of a byte, `dc` equals that byte's `in_is_data` tag: 1 for display data, 0 for a command.
- R4: Between rising edges of a byte, `sclk` stays high for exactly `HALF_DIV` system clocks and low for exactly `HALF_DIV` system clocks.
- R5: `sclk` is 0 whenever `cs_n` is 1. `cs_n` is 0 at every rising `sclk` edge, and it falls at least `SETUP_CYC` clocks before the first rising edge of a transfer.
- R6: `cs_n` stays low for at least `HALF_DIV + HOLD_CYC` clocks after the last rising edge. `sdo` and `dc` never change while `sclk` is high.
- R7: A byte is taken only when `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the last cycle of the hold interval. Changes on `in_byte` and `in_is_data` while no handshake occurs have no effect on the serial output.
- R8: If `in_valid` is 1 in the last hold cycle, that byte is accepted and `cs_n` stays low across both bytes.
- R9: If no byte is valid in the last hold cycle, `cs_n` rises and the block returns to idle.
- R10: `busy` is 1 exactly while `cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte offered on in_byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Byte to send, bit 7 goes first |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the receiver |
| dc | output | 1 | Data/command select for the current byte |
| busy | output | 1 | A byte is in flight |

## Verification
`cs_n` and `busy` change on the accepting edge, and `in_ready` is low from the next cycle. The first `sclk` rise follows `SETUP_CYC` clocks after that edge. Each `sclk` level then lasts `HALF_DIV` clocks, and `cs_n` rises `HALF_DIV + HOLD_CYC` clocks after the last rise. The bench samples every output on the falling system clock edge and finds `sclk` transitions by comparing each sample with the one before. It counts the cycles between events and compares the counts with these figures.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_SHIFT = 2'd2,
    ST_HOLD  = 2'd3
  } sdw_state_e;
endpackage

// File: rtl/sdw_timer.sv
module sdw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assign done = (cnt == limit - 1'b1);

  // R4: the count never passes the selected limit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/sdw_shreg.sv
module sdw_shreg #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] din,
  input  logic            shift,
  output logic            msb
);
  logic [BITS-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[BITS-2:0], 1'b0};
  end

  assign msb = sr[BITS-1];

  // R7: a new byte is never loaded in the same cycle as a shift
  a_r7_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/spi_disp_writer.sv
module spi_disp_writer #(
  parameter int BITS      = 8,
  parameter int HALF_DIV  = 10,
  parameter int SETUP_CYC = 10,
  parameter int HOLD_CYC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BITS-1:0] in_byte,
  input  logic            in_is_data,
  output logic            cs_n,
  output logic            sclk,
  output logic            sdo,
  output logic            dc,
  output logic            busy
);
  import sdw_pkg::*;

  localparam int MAXC = (HALF_DIV > SETUP_CYC)
                        ? ((HALF_DIV > HOLD_CYC) ? HALF_DIV : HOLD_CYC)
                        : ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC);
  localparam int TW = $clog2(MAXC + 1);
  localparam int BW = (BITS > 2) ? $clog2(BITS) : 1;

  sdw_state_e     state;
  logic           sclk_q, dc_q, cs_q;
  logic [BW-1:0]  bit_q;
  logic [TW-1:0]  limit;
  logic           t_done, accept, last_bit, fall, shift_en, t_clear;

  always_comb begin
    case (state)
      ST_SETUP: limit = TW'(SETUP_CYC);
      ST_HOLD:  limit = TW'(HOLD_CYC);
      default:  limit = TW'(HALF_DIV);
    endcase
  end

  assign in_ready = (state == ST_IDLE) || ((state == ST_HOLD) && t_done);
  assign accept   = in_valid && in_ready;
  assign last_bit = (bit_q == BW'(BITS - 1));
  assign fall     = (state == ST_SHIFT) && t_done && sclk_q;
  assign shift_en = fall && !last_bit;
  assign t_clear  = t_done || accept;

  sdw_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (t_clear),
    .limit (limit),
    .done  (t_done)
  );

  sdw_shreg #(.BITS(BITS)) u_shreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (in_byte),
    .shift (shift_en),
    .msb   (sdo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sclk_q <= 1'b0;
      dc_q   <= 1'b0;
      cs_q   <= 1'b1;
      bit_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_SETUP;
          cs_q  <= 1'b0;
          dc_q  <= in_is_data;
          bit_q <= '0;
        end
        ST_SETUP: if (t_done) begin
          state  <= ST_SHIFT;
          sclk_q <= 1'b1;
        end
        ST_SHIFT: if (t_done) begin
          if (!sclk_q) sclk_q <= 1'b1;
          else begin
            sclk_q <= 1'b0;
            if (last_bit) state <= ST_HOLD;
            else          bit_q <= bit_q + 1'b1;
          end
        end
        default: if (t_done) begin
          if (in_valid) begin
            state <= ST_SETUP;
            dc_q  <= in_is_data;
            bit_q <= '0;
          end else begin
            state <= ST_IDLE;
            cs_q  <= 1'b1;
          end
        end
      endcase
    end
  end

  assign cs_n = cs_q;
  assign sclk = sclk_q;
  assign dc   = dc_q;
  assign busy = (state != ST_IDLE);

  // Checker state: length of the current high phase of sclk
  logic [TW:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (sclk_q) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  // R5
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R6
  a_r6_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(sdo) && $stable(dc)));
  // R4
  a_r4_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == (TW+1)'(HALF_DIV)));
  // R7
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(accept)) |-> !in_ready);
  // R10
  a_r10_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  // R2
  a_r2_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> last_bit);
endmodule

// File: tb/sim_spi_disp_writer.sv
module sim_spi_disp_writer;
  localparam int H  = 10;
  localparam int SU = 10;
  localparam int HO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_is_data = 1'b0;
  logic in_ready, cs_n, sclk, sdo, dc, busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] got_b [0:63];
  logic       got_d [0:63];
  int got_n = 0;
  int frames = 0;

  always #5 clk = ~clk;

  spi_disp_writer #(.BITS(8), .HALF_DIV(H), .SETUP_CYC(SU), .HOLD_CYC(HO)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .dc(dc), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Protocol monitor, sampled on the falling system clock edge
  logic ps = 1'b0, pcs = 1'b1, psdo = 1'b0, pdc = 1'b0, first_dc = 1'b0;
  int run = 0, cs_low = 0, since_rise = 0, nbit = 0, byte_in_frame = 0;
  logic [7:0] sh = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && pcs) begin
        cs_low = 0; byte_in_frame = 0;
        chk(busy == 1'b1, "R10", busy, 1);
      end else cs_low++;
      since_rise++;
      if (cs_n) chk(sclk == 1'b0, "R5", sclk, 0);
      if (sclk && ps) begin
        chk(sdo == psdo, "R6", sdo, psdo);
        chk(dc == pdc, "R6", dc, pdc);
        chk(!in_ready, "R7", in_ready, 0);
      end
      if (sclk != ps) begin
        if (ps) chk(run == H, "R4", run, H);
        else if (nbit != 0) chk(run == H, "R4", run, H);
        if (sclk) begin
          chk(cs_n == 1'b0, "R5", cs_n, 0);
          if (nbit == 0) begin
            if (byte_in_frame == 0) chk(cs_low >= SU, "R5", cs_low, SU);
            else chk(run >= H, "R4", run, H);
            first_dc = dc;
          end else chk(dc == first_dc, "R3", dc, first_dc);
          sh = {sh[6:0], sdo};
          nbit = (nbit + 1) % 8;
          if (nbit == 0 && got_n < 64) begin
            got_b[got_n] = sh; got_d[got_n] = first_dc; got_n++;
            byte_in_frame++;
          end
          since_rise = 0;
        end
        run = 1;
      end else run++;
      if (cs_n && !pcs) begin
        chk(since_rise >= H + HO, "R6", since_rise, H + HO);
        chk(nbit == 0, "R2", nbit, 0);
        chk(busy == 1'b0, "R10", busy, 0);
        frames++;
      end
      ps = sclk; pcs = cs_n; psdo = sdo; pdc = dc;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  // Called on a falling edge; returns on the falling edge after acceptance
  task automatic push(input logic [7:0] b, input logic d);
    in_valid = 1'b1; in_byte = b; in_is_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7", in_ready, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_byte(input int idx, input logic [7:0] b, input logic d);
    chk(got_n > idx, "R2", got_n, idx + 1);
    if (got_n > idx) begin
      chk(got_b[idx] == b, "R2", got_b[idx], b);
      chk(got_d[idx] == d, "R3", got_d[idx], d);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", cs_n, 1);
    chk(sclk == 1'b0, "R1", sclk, 0);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(in_ready == 1'b1, "R1", in_ready, 1);
  endtask

  task automatic t_single(input logic [7:0] b, input logic d);
    int n0, f0;
    n0 = got_n; f0 = frames;
    @(negedge clk);
    push(b, d);
    chk(busy == 1'b1, "R10", busy, 1);
    wait_idle();
    expect_byte(n0, b, d);
    chk(frames == f0 + 1, "R9", frames, f0 + 1);
    chk(in_ready == 1'b1, "R9", in_ready, 1);
  endtask

  task automatic t_burst();
    int n0, f0;
    n0 = got_n; f0 = frames;
    @(negedge clk);
    push(8'h15, 1'b0);
    push(8'hC3, 1'b1);
    push(8'h7E, 1'b1);
    wait_idle();
    expect_byte(n0, 8'h15, 1'b0);
    expect_byte(n0 + 1, 8'hC3, 1'b1);
    expect_byte(n0 + 2, 8'h7E, 1'b1);
    chk(frames == f0 + 1, "R8", frames, f0 + 1);
  endtask

  task automatic t_ignore();
    int n0;
    n0 = got_n;
    @(negedge clk);
    push(8'h5A, 1'b0);
    for (int i = 0; i < 60; i++) begin
      in_byte = 8'(i * 37); in_is_data = i[0];
      @(negedge clk);
    end
    wait_idle();
    expect_byte(n0, 8'h5A, 1'b0);
    chk(got_n == n0 + 1, "R7", got_n, n0 + 1);
  endtask

  task automatic t_gap();
    int n0, f0;
    n0 = got_n; f0 = frames;
    @(negedge clk);
    push(8'h81, 1'b1);
    wait_idle();
    repeat (5) @(negedge clk);
    push(8'h24, 1'b0);
    wait_idle();
    expect_byte(n0, 8'h81, 1'b1);
    expect_byte(n0 + 1, 8'h24, 1'b0);
    chk(frames == f0 + 2, "R9", frames, f0 + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single(8'hA5, 1'b0);
    t_single(8'h3C, 1'b1);
    t_single(8'h00, 1'b1);
    t_single(8'hFF, 1'b0);
    t_single(8'h80, 1'b1);
    t_single(8'h01, 1'b0);
    t_burst();
    t_ignore();
    t_gap();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule